// File: doc/BRIEF.md
# Statistics Capture and Dump Controller

This block decides when a traffic statistics probe is collecting and when the probe's counters are emitted. Three enables set by software gate collection: a master enable that also drives the probe's clock-gate enable, a software enable, and a trigger-mode enable. In trigger mode, external start and stop pulses arm and disarm collection. Writes arrive on a simple register write port. There is no read path.

Dumps are either periodic or manual. In periodic mode a cycle timer counts the cycles in which collection is active. When the count reaches the programmed interval, the block issues a one-cycle dump strobe to the frame formatter and a one-cycle clear strobe to the counters. In manual mode the timer is held at zero, and a dump occurs only when software writes 1 to the send bit. The send bit clears itself. A fixed probe identifier, set by a parameter, is presented alongside every dump.

Register slots, with the write data taken from bit 0 unless noted:

- slot 0: master enable
- slot 1: software enable
- slot 2: trigger-mode enable
- slot 3: interval, bits [15:0]
- slot 4: manual mode
- slot 5: send

Writes to slots 6 and 7 are ignored.

Top module: `stat_dump_ctrl`

## Requirements
- R1: After reset, all enables, the interval and the manual-mode bit are 0, and `collect_active`, `clk_gate_en`, `dump_strobe` and `clear_strobe` are all 0.
- R2: `clk_gate_en` equals the master enable bit, which takes the value written to slot 0 bit 0 on the clock edge that performs the write.
- R3: `collect_active` is 1 exactly when the master enable, the software enable, and (trigger-mode disabled or trigger armed) all hold.
- R4: With trigger mode on, a `trig_start` pulse arms collection and a `trig_stop` pulse disarms it. Stop wins when both pulses arrive in the same cycle. While trigger mode is off, the armed state is held at 0 and trigger pulses are ignored.
- R5: In periodic mode (manual bit 0) with interval N > 0, the dump fires on the (N+1)th active cycle after the timer was last zero. The strobes appear one cycle after that edge, so dumps repeat every N+1 active cycles.
- R6: An interval of 0 in periodic mode produces no dumps.
- R7: The timer holds while collection is inactive only because trigger mode is disarmed. The timer resets to 0 whenever the master or software enable is 0.
- R8: In manual mode there are no timed dumps. Writing 1 to slot 5 gives one dump in the following cycle. Writing 0 to slot 5, or writing slot 5 in periodic mode, has no effect.
- R9: `dump_strobe` and `clear_strobe` are identical, and each lasts exactly one cycle. A send written while a strobe is high is dropped.
- R10: `dump_id` equals the parameter PROBE_ID (default 0) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register slot |
| cfg_wdata | input | 16 | Write data |
| trig_start | input | 1 | External start pulse |
| trig_stop | input | 1 | External stop pulse |
| collect_active | output | 1 | Probe is collecting |
| clk_gate_en | output | 1 | Probe clock-gate enable |
| dump_strobe | output | 1 | One-cycle request to emit a frame |
| clear_strobe | output | 1 | One-cycle counter reinitialise |
| dump_id | output | 2 | Probe identifier for the frame |

## Verification
A wrong armed or enable bit is visible on `collect_active` within the same cycle. A stray or missing timer count cannot be seen directly; it appears only as a dump strobe that arrives early or late, up to N+1 cycles later. The bench therefore compares every output in every cycle against a model built from the requirements. It also measures the distance to the first dump after the enables are cycled. Manual sends are checked for exactly one strobe in the cycle after the write, and for no strobe when the send is not valid.

// File: rtl/stat_dump_ctrl.sv
module stat_dump_ctrl #(
  parameter int IW = 16,
  parameter int AW = 3,
  parameter int IDW = 2,
  parameter logic [IDW-1:0] PROBE_ID = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [IW-1:0]  cfg_wdata,
  input  logic           trig_start,
  input  logic           trig_stop,
  output logic           collect_active,
  output logic           clk_gate_en,
  output logic           dump_strobe,
  output logic           clear_strobe,
  output logic [IDW-1:0] dump_id
);
  localparam logic [AW-1:0] A_MASTER = AW'(0);
  localparam logic [AW-1:0] A_SOFT   = AW'(1);
  localparam logic [AW-1:0] A_TRIG   = AW'(2);
  localparam logic [AW-1:0] A_IVAL   = AW'(3);
  localparam logic [AW-1:0] A_MANUAL = AW'(4);
  localparam logic [AW-1:0] A_SEND   = AW'(5);

  logic          master_q, soft_q, trig_q, manual_q, armed_q, dump_q;
  logic [IW-1:0] ival_q, cnt_q;

  wire wr_send  = cfg_we && cfg_addr == A_SEND && cfg_wdata[0];
  wire auto_on  = master_q && soft_q && !manual_q && ival_q != '0;
  wire tick_hit = auto_on && collect_active && cnt_q >= ival_q;
  wire send_hit = wr_send && manual_q && !dump_q;

  assign collect_active = master_q && soft_q && (!trig_q || armed_q);
  assign clk_gate_en    = master_q;
  assign dump_strobe    = dump_q;
  assign clear_strobe   = dump_q;
  assign dump_id        = PROBE_ID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      soft_q   <= 1'b0;
      trig_q   <= 1'b0;
      manual_q <= 1'b0;
      ival_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_MASTER: master_q <= cfg_wdata[0];
        A_SOFT:   soft_q   <= cfg_wdata[0];
        A_TRIG:   trig_q   <= cfg_wdata[0];
        A_IVAL:   ival_q   <= cfg_wdata;
        A_MANUAL: manual_q <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (!trig_q)    armed_q <= 1'b0;
    else if (trig_stop)  armed_q <= 1'b0;
    else if (trig_start) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!auto_on)       cnt_q <= '0;
    else if (tick_hit)       cnt_q <= '0;
    else if (collect_active) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dump_q <= 1'b0;
    else        dump_q <= tick_hit || send_hit;
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |=> !dump_q);
  assert_gate_covers_collect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    collect_active |-> clk_gate_en);
  assert_idle_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ival_q == '0 || manual_q) |=> cnt_q == '0);
  assert_manual_dump_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_q ##1 dump_q) |-> $past(wr_send));
  assert_stop_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stop || !trig_q) |=> !armed_q);
  assert_timer_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_q && soft_q) |=> cnt_q == '0);
endmodule

// File: tb/tb_stat_dump_ctrl.sv
module tb_stat_dump_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic trig_start = 1'b0, trig_stop = 1'b0;
  logic collect_active, clk_gate_en, dump_strobe, clear_strobe;
  logic [1:0] dump_id;

  stat_dump_ctrl dut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .trig_start,
    .trig_stop, .collect_active, .clk_gate_en, .dump_strobe, .clear_strobe, .dump_id);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nbad = 0;
  bit done = 0;

  // reference state built from the requirements
  bit m_master, m_soft, m_trig, m_man, m_armed, m_strobe;
  int m_ival, m_cnt;

  function automatic bit m_active();
    return m_master && m_soft && (!m_trig || m_armed);
  endfunction

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit fire = 0, send;
    send = cfg_we && cfg_addr == 3'd5 && cfg_wdata[0] && m_man && !m_strobe;
    if (!m_master || !m_soft || m_man || m_ival == 0) m_cnt = 0;
    else if (m_active()) begin
      if (m_cnt >= m_ival) begin fire = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (!m_trig) m_armed = 0;
    else if (trig_stop) m_armed = 0;
    else if (trig_start) m_armed = 1;
    m_strobe = fire || send;
    if (cfg_we) case (cfg_addr)
      3'd0: m_master = cfg_wdata[0];
      3'd1: m_soft = cfg_wdata[0];
      3'd2: m_trig = cfg_wdata[0];
      3'd3: m_ival = cfg_wdata;
      3'd4: m_man = cfg_wdata[0];
      default: ;
    endcase
  endtask

  task automatic compare_all();
    check("R3", collect_active, m_active());
    check("R2", clk_gate_en, m_master);
    check("R5", dump_strobe, m_strobe);
    check("R9", clear_strobe, dump_strobe);
    check("R10", dump_id, 0);
  endtask

  // called at a negedge; leaves at the following negedge
  task automatic step(bit we = 0, int a = 0, int d = 0, bit st = 0, bit sp = 0);
    cfg_we = we; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    trig_start = st; trig_stop = sp;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_we = 0; trig_start = 0; trig_stop = 0;
    compare_all();
  endtask

  task automatic wr(int a, int d); step(1, a, d); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int first, cnt;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", collect_active, 0); check("R1", clk_gate_en, 0);
    check("R1", dump_strobe, 0);    check("R1", clear_strobe, 0);
    check("R10", dump_id, 0);
    // R6: enabled, interval 0
    wr(0, 1); check("R2", clk_gate_en, 1);
    wr(1, 1); check("R3", collect_active, 1);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin step(); cnt += dump_strobe; end
    check("R6", cnt, 0);
    // R5: interval 3
    wr(3, 3);
    first = 0; cnt = 0;
    for (int i = 1; i <= 8; i++) begin
      step(); if (dump_strobe) begin cnt++; if (first == 0) first = i; end
    end
    check("R5", first, 4); check("R5", cnt, 2);
    // R7: clearing soft enable restarts the timer
    step(); step(); wr(1, 0); wr(1, 1);
    first = 0;
    for (int i = 1; i <= 6; i++) begin step(); if (dump_strobe && first == 0) first = i; end
    check("R7", first, 4);
    // R4: trigger mode
    wr(2, 1); check("R4", collect_active, 0);
    step(0, 0, 0, 1, 0); check("R4", collect_active, 1);
    step(0, 0, 0, 0, 1); check("R4", collect_active, 0);
    step(0, 0, 0, 1, 1); check("R4", collect_active, 0);
    wr(2, 0); step(0, 0, 0, 1, 0); check("R4", collect_active, 1);
    wr(2, 1); check("R4", collect_active, 0);
    wr(2, 0);
    // R8: manual mode
    wr(4, 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt += dump_strobe; end
    check("R8", cnt, 0);
    wr(5, 1); check("R8", dump_strobe, 1); check("R9", clear_strobe, 1);
    step(); check("R9", dump_strobe, 0);
    wr(5, 0); check("R8", dump_strobe, 0);
    wr(5, 1); step(1, 5, 1); check("R9", dump_strobe, 0);
    wr(4, 0); wr(3, 0); wr(5, 1); check("R8", dump_strobe, 0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int a = $urandom % 8;
      int d = (a == 3) ? $urandom % 6 : (($urandom % 4) != 0);
      bit we = ($urandom % 5) == 0;
      step(we, a, d, ($urandom % 6) == 0, ($urandom % 9) == 0);
    end
    finish_run();
  end
endmodule